// File: doc/BRIEF.md
# Integer Speculative and Committed Register File

This block holds the integer register state of an out-of-order core in two copies. The committed copy holds the sixteen program-visible registers as of the last retired instruction. The speculative copy holds the newest in-flight value of each of those sixteen registers. Eight more scratch registers serve microcode. Together that is 40 entries of 64 bits.

Issue-side logic reads through three combinational read ports and writes results through three speculative write ports. The retire stage writes committed values through three retire ports. When a branch mispredict or an exception forces a restart, a single rollback strobe copies the whole committed copy over the speculative copy in one clock. The scratch registers have only one copy. They are read and written directly and are left untouched by rollback.

Top module: `int_future_file`

## Requirements
- R1: After reset all 40 registers are zero, so every read port returns zero for every index.
- R2: Each of the three read ports is combinational and independent. Index 0..15 returns the speculative copy and index 16..23 returns scratch register (index-16). Index 24..31 returns zero, and a speculative write to those indices has no effect.
- R3: A speculative write to index 0..15 updates the speculative copy at the clock edge. It is visible on a read in the following cycle, and a read in the same cycle returns the old value.
- R4: The committed copy changes only through a retire write. A speculative write never alters it, which shows after a later rollback.
- R5: A retire write (4-bit index 0..15) updates the committed copy only. Reads of the speculative copy do not change.
- R6: A rollback strobe copies all 16 committed registers into the speculative copy in one cycle.
- R7: When a rollback and a speculative write to index 0..15 occur in the same cycle, the rollback wins.
- R8: When a rollback and a retire write occur in the same cycle, the restored value is the newly retired one.
- R9: A speculative write to index 16..23 updates scratch directly, including in a rollback cycle. Rollback leaves scratch unchanged.
- R10: When several speculative write ports target the same index in one cycle, the highest-numbered port wins.
- R11: When several retire ports target the same index in one cycle, the highest-numbered port wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rd_addr_i | input | 3x5 | Read index per read port |
| rd_data_o | output | 3x64 | Read data per read port |
| spec_we_i | input | 3 | Speculative write enables |
| spec_addr_i | input | 3x5 | Speculative write indices |
| spec_data_i | input | 3x64 | Speculative write data |
| ret_we_i | input | 3 | Retire write enables |
| ret_addr_i | input | 3x4 | Retire write indices |
| ret_data_i | input | 3x64 | Retire write data |
| rollback_i | input | 1 | Restore speculative copy from committed copy |

## Verification
The bench targets four same-cycle collisions:
- Rollback with a retire write. A design that restored the pre-retire value would lose the newest commit.
- Rollback with a speculative write. Letting the write through would leave a wrong-path value live after the restart.
- Two ports writing one index. A design with the wrong port priority returns a lower port's data.
- Rollback with a scratch write. Dropping that write, or restoring scratch on rollback, corrupts microcode state.

The bench also checks that a speculative value never reaches the committed copy by rolling back after a speculative write. Random traffic with frequent rollbacks runs against a bench-side model of both copies.

// File: rtl/ifrf_pkg.sv
package ifrf_pkg;
  localparam int unsigned XLEN    = 64;
  localparam int unsigned N_ARCH  = 16;
  localparam int unsigned N_SCR   = 8;
  localparam int unsigned N_RD    = 3;
  localparam int unsigned N_SPEC  = 3;
  localparam int unsigned N_RET   = 3;
  localparam int unsigned IDX_W   = $clog2(N_ARCH + N_SCR);
  localparam int unsigned ARCH_W  = $clog2(N_ARCH);
endpackage

// File: rtl/ifrf_wr_sel.sv
// Per-register write select across ports; highest port index wins.
module ifrf_wr_sel #(
  parameter int unsigned NPORT = 3,
  parameter int unsigned AW    = 5,
  parameter int unsigned DW    = 64,
  parameter int unsigned IDX   = 0
) (
  input  logic [NPORT-1:0]         we_i,
  input  logic [NPORT-1:0][AW-1:0] addr_i,
  input  logic [NPORT-1:0][DW-1:0] data_i,
  output logic                     hit_o,
  output logic [DW-1:0]            data_o
);
  always_comb begin
    hit_o  = 1'b0;
    data_o = '0;
    for (int p = 0; p < NPORT; p++) begin
      if (we_i[p] && addr_i[p] == AW'(IDX)) begin
        hit_o  = 1'b1;
        data_o = data_i[p];
      end
    end
  end
endmodule

// File: rtl/ifrf_rd_mux.sv
module ifrf_rd_mux #(
  parameter int unsigned AW     = 5,
  parameter int unsigned DW     = 64,
  parameter int unsigned N_ARCH = 16,
  parameter int unsigned N_SCR  = 8
) (
  input  logic [AW-1:0]              addr_i,
  input  logic [N_ARCH-1:0][DW-1:0]  fut_i,
  input  logic [N_SCR-1:0][DW-1:0]   scr_i,
  output logic [DW-1:0]              data_o
);
  localparam int unsigned FW = $clog2(N_ARCH);
  localparam int unsigned SW = $clog2(N_SCR);

  logic [FW-1:0] fut_idx;
  logic [SW-1:0] scr_idx;
  logic [AW-1:0] scr_off;

  assign fut_idx = addr_i[FW-1:0];
  assign scr_off = addr_i - AW'(N_ARCH);
  assign scr_idx = scr_off[SW-1:0];

  always_comb begin
    if (addr_i < AW'(N_ARCH))               data_o = fut_i[fut_idx];
    else if (addr_i < AW'(N_ARCH + N_SCR))  data_o = scr_i[scr_idx];
    else                                    data_o = '0;
  end
endmodule

// File: rtl/int_future_file.sv
module int_future_file
  import ifrf_pkg::*;
#(
  parameter int unsigned DW   = XLEN,
  parameter int unsigned NA   = N_ARCH,
  parameter int unsigned NS   = N_SCR,
  parameter int unsigned NRD  = N_RD,
  parameter int unsigned NSW  = N_SPEC,
  parameter int unsigned NRT  = N_RET,
  parameter int unsigned AW   = IDX_W,
  parameter int unsigned RAW  = ARCH_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [NRD-1:0][AW-1:0]  rd_addr_i,
  output logic [NRD-1:0][DW-1:0]  rd_data_o,
  input  logic [NSW-1:0]          spec_we_i,
  input  logic [NSW-1:0][AW-1:0]  spec_addr_i,
  input  logic [NSW-1:0][DW-1:0]  spec_data_i,
  input  logic [NRT-1:0]          ret_we_i,
  input  logic [NRT-1:0][RAW-1:0] ret_addr_i,
  input  logic [NRT-1:0][DW-1:0]  ret_data_i,
  input  logic                    rollback_i
);
  logic [NA-1:0][DW-1:0] arch_q, arch_d, fut_q, fut_d;
  logic [NS-1:0][DW-1:0] scr_q, scr_d;

  for (genvar i = 0; i < NA; i++) begin : g_arch
    logic          ret_hit, spec_hit;
    logic [DW-1:0] ret_val, spec_val;

    ifrf_wr_sel #(.NPORT(NRT), .AW(RAW), .DW(DW), .IDX(i)) u_ret_sel (
      .we_i(ret_we_i), .addr_i(ret_addr_i), .data_i(ret_data_i),
      .hit_o(ret_hit), .data_o(ret_val)
    );
    ifrf_wr_sel #(.NPORT(NSW), .AW(AW), .DW(DW), .IDX(i)) u_spec_sel (
      .we_i(spec_we_i), .addr_i(spec_addr_i), .data_i(spec_data_i),
      .hit_o(spec_hit), .data_o(spec_val)
    );

    assign arch_d[i] = ret_hit ? ret_val : arch_q[i];
    // rollback restores post-retire value and overrides speculative writes
    assign fut_d[i]  = rollback_i ? arch_d[i] : (spec_hit ? spec_val : fut_q[i]);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        arch_q[i] <= '0;
        fut_q[i]  <= '0;
      end else begin
        arch_q[i] <= arch_d[i];
        fut_q[i]  <= fut_d[i];
      end
    end
  end

  for (genvar j = 0; j < NS; j++) begin : g_scr
    logic          hit;
    logic [DW-1:0] val;

    ifrf_wr_sel #(.NPORT(NSW), .AW(AW), .DW(DW), .IDX(NA + j)) u_scr_sel (
      .we_i(spec_we_i), .addr_i(spec_addr_i), .data_i(spec_data_i),
      .hit_o(hit), .data_o(val)
    );

    assign scr_d[j] = hit ? val : scr_q[j];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) scr_q[j] <= '0;
      else         scr_q[j] <= scr_d[j];
    end
  end

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    ifrf_rd_mux #(.AW(AW), .DW(DW), .N_ARCH(NA), .N_SCR(NS)) u_rd (
      .addr_i(rd_addr_i[r]), .fut_i(fut_q), .scr_i(scr_q), .data_o(rd_data_o[r])
    );
  end

  a_r4_arch_only_on_retire: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|ret_we_i) |=> $stable(arch_q));

  a_r6_rollback_restores: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rollback_i && !(|ret_we_i)) |=> (fut_q == arch_q));

  a_r3_future_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rollback_i && !(|spec_we_i)) |=> $stable(fut_q));

  a_r9_scratch_keeps_on_rollback: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rollback_i && !(|spec_we_i)) |=> $stable(scr_q));

  a_r5_retire_no_future_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rollback_i && !(|spec_we_i) && (|ret_we_i)) |=> $stable(fut_q));
endmodule

// File: tb/int_future_file_test.sv
`timescale 1ns/1ps
module int_future_file_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0][4:0]  rd_addr;
  logic [2:0][63:0] rd_data;
  logic [2:0]       spec_we;
  logic [2:0][4:0]  spec_addr;
  logic [2:0][63:0] spec_data;
  logic [2:0]       ret_we;
  logic [2:0][3:0]  ret_addr;
  logic [2:0][63:0] ret_data;
  logic             rollback;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [63:0] m_arch [16];
  logic [63:0] m_fut  [16];
  logic [63:0] m_scr  [8];

  always #2.5 clk = ~clk;

  int_future_file uut (
    .clk_i(clk), .rst_ni(rst_n),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .spec_we_i(spec_we), .spec_addr_i(spec_addr), .spec_data_i(spec_data),
    .ret_we_i(ret_we), .ret_addr_i(ret_addr), .ret_data_i(ret_data),
    .rollback_i(rollback)
  );

  function automatic logic [63:0] m_read(input logic [4:0] a);
    if (a < 5'd16)      return m_fut[a[3:0]];
    else if (a < 5'd24) return m_scr[a[2:0]];
    else                return 64'd0;
  endfunction

  // Model of one clock edge, derived from the requirements
  function automatic void m_update();
    for (int p = 0; p < 3; p++)
      if (ret_we[p]) m_arch[ret_addr[p]] = ret_data[p];
    if (rollback) begin
      for (int i = 0; i < 16; i++) m_fut[i] = m_arch[i];
    end else begin
      for (int p = 0; p < 3; p++)
        if (spec_we[p] && spec_addr[p] < 5'd16) m_fut[spec_addr[p][3:0]] = spec_data[p];
    end
    for (int p = 0; p < 3; p++)
      if (spec_we[p] && spec_addr[p] >= 5'd16 && spec_addr[p] < 5'd24)
        m_scr[spec_addr[p][2:0]] = spec_data[p];
  endfunction

  task automatic clear_in();
    spec_we = '0; spec_addr = '0; spec_data = '0;
    ret_we = '0; ret_addr = '0; ret_data = '0;
    rollback = 1'b0;
  endtask

  task automatic tick();
    @(posedge clk);
    m_update();
    @(negedge clk);
    clear_in();
  endtask

  task automatic chk3(input logic [4:0] a0, input logic [4:0] a1,
                      input logic [4:0] a2, input string tag);
    rd_addr[0] = a0; rd_addr[1] = a1; rd_addr[2] = a2;
    #0.5;
    for (int p = 0; p < 3; p++) begin
      checks++;
      if (rd_data[p] !== m_read(rd_addr[p])) begin
        errors++;
        $display("FAIL %s port%0d idx%0d: got %h expected %h", tag, p, rd_addr[p],
                 rd_data[p], m_read(rd_addr[p]));
      end
    end
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1F2E3D4C));
    for (int i = 0; i < 16; i++) begin m_arch[i] = '0; m_fut[i] = '0; end
    for (int i = 0; i < 8; i++) m_scr[i] = '0;
    clear_in();
    rd_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk3(5'd0, 5'd16, 5'd31, "R1");
    chk3(5'd15, 5'd23, 5'd7, "R1");

    // R3 same-cycle read old, next-cycle new
    spec_we[0] = 1'b1; spec_addr[0] = 5'd3; spec_data[0] = 64'hA5A5_0000_1111_0003;
    chk3(5'd3, 5'd3, 5'd3, "R3");
    tick();
    chk3(5'd3, 5'd4, 5'd2, "R3");

    // R10 all spec ports on one index
    for (int p = 0; p < 3; p++) begin
      spec_we[p] = 1'b1; spec_addr[p] = 5'd5; spec_data[p] = 64'hBEEF_0000_0000_0050 + 64'(p);
    end
    tick();
    chk3(5'd5, 5'd5, 5'd3, "R10");

    // R9 scratch write; R2 write beyond 23 ignored
    spec_we[1] = 1'b1; spec_addr[1] = 5'd18; spec_data[1] = 64'h5C5C_0000_0000_0012;
    spec_we[2] = 1'b1; spec_addr[2] = 5'd27; spec_data[2] = 64'hDEAD_DEAD_DEAD_DEAD;
    tick();
    chk3(5'd18, 5'd27, 5'd16, "R9");
    chk3(5'd27, 5'd24, 5'd31, "R2");

    // R5 retire does not touch future copy
    ret_we[0] = 1'b1; ret_addr[0] = 4'd3; ret_data[0] = 64'hC0C0_0000_0000_0B03;
    tick();
    chk3(5'd3, 5'd5, 5'd18, "R5");

    // R6/R4 rollback: retired value comes back, speculative-only writes vanish
    rollback = 1'b1;
    tick();
    chk3(5'd3, 5'd5, 5'd0, "R6");
    chk3(5'd5, 5'd18, 5'd3, "R4");

    // R11 retire priority
    for (int p = 0; p < 3; p++) begin
      ret_we[p] = 1'b1; ret_addr[p] = 4'd7; ret_data[p] = 64'h7777_0000_0000_0070 + 64'(p);
    end
    tick();
    // R7 rollback beats speculative write
    rollback = 1'b1;
    spec_we[2] = 1'b1; spec_addr[2] = 5'd7; spec_data[2] = 64'hBAD0_BAD0_BAD0_BAD0;
    tick();
    chk3(5'd7, 5'd7, 5'd7, "R11");
    chk3(5'd7, 5'd3, 5'd5, "R7");

    // R8 rollback with same-cycle retire
    rollback = 1'b1;
    ret_we[1] = 1'b1; ret_addr[1] = 4'd9; ret_data[1] = 64'h9999_0000_0000_0C09;
    tick();
    chk3(5'd9, 5'd9, 5'd7, "R8");

    // R9 scratch write during rollback
    spec_we[0] = 1'b1; spec_addr[0] = 5'd3; spec_data[0] = 64'h1234_5678_9ABC_DEF0;
    spec_we[1] = 1'b1; spec_addr[1] = 5'd10; spec_data[1] = 64'h4321_0000_0000_0001;
    tick();
    rollback = 1'b1;
    spec_we[0] = 1'b1; spec_addr[0] = 5'd20; spec_data[0] = 64'h2020_2020_2020_2020;
    tick();
    chk3(5'd20, 5'd18, 5'd3, "R9");
    chk3(5'd10, 5'd9, 5'd23, "R6");

    // Random traffic
    for (int n = 0; n < 3000; n++) begin
      for (int p = 0; p < 3; p++) begin
        spec_we[p]   = ($urandom % 3) != 0;
        spec_addr[p] = 5'($urandom % 26);
        spec_data[p] = {$urandom, $urandom};
        ret_we[p]    = ($urandom % 3) == 0;
        ret_addr[p]  = 4'($urandom % 16);
        ret_data[p]  = {$urandom, $urandom};
      end
      rollback = ($urandom % 12) == 0;
      chk3(5'($urandom % 32), 5'($urandom % 32), 5'($urandom % 24), "R2");
      tick();
    end
    chk3(5'd0, 5'd1, 5'd2, "R4");
    rollback = 1'b1;
    tick();
    for (int i = 0; i < 16; i += 3)
      chk3(5'(i), 5'(i + 1), 5'(i + 2), "R6");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule